// File: doc/BRIEF.md
# Two-Phase Watchdog Timer

This block is a watchdog timer with two consecutive timeout phases, driven from a small 32-bit register interface of three words. While it is enabled, a prescaler divides the input clock into watchdog ticks. The tick is a base period of 2^BASE_LOG2 clock cycles, multiplied by 1, 2, 4 or 8 through a two-bit logarithmic select. The first phase counts its programmed number of ticks and then raises a sticky pre-timeout flag and an interrupt. From that point software can no longer turn the timer off. The second phase counts its own number of ticks and then issues a one-cycle pulse on one of three reset outputs, picked by a two-bit reset mode.

Software keeps the system alive by writing a kick word to the kick register. Each kick restarts the prescaler and puts the sequence back at the start of the first phase. With zero in both limit fields, the enable bit plus a mode gives the quickest route to a reset: one tick per phase. After the reset pulse the timer falls back to its disabled idle state. BASE_LOG2 defaults to 25, which gives a base tick of about 168 ms at 200 MHz. A small value shortens runs in simulation.

Top module: `wdt_two_phase`

## Requirements
- R1: After reset the control word reads 0x0000_0001 (timer disabled, reset mode 1, all limit and scale fields zero), the status word reads zero, and the interrupt and all reset outputs are low.
- R2: A tick lasts 2^(BASE_LOG2+S) clock cycles, where S is control bits 30:29. Counting starts at the write that sets the enable bit (control bit 31) or at a kick.
- R3: The first phase ends after (L1+1) ticks, where L1 is control bits 26:22. At the clock edge that ends it, status bit 31 becomes 1 and the interrupt output goes high.
- R4: The second phase ends (L2+1) ticks after the first, where L2 is control bits 19:15. At that edge exactly one reset output pulses high for one cycle, status bit 30 becomes 1, and the enable bit reads back 0.
- R5: Reset mode (control bits 1:0) selects the output: 0 pulses the full-chip reset, 1 the CPU reset, 2 the software reset, and 3 is treated as 0. Two reset outputs are never high together.
- R6: A write to offset 0x0 with bit 31 set restarts the prescaler and the first phase, so the first phase then ends (L1+1) ticks after the kick. The same write with bit 31 clear has no effect on timing.
- R7: Clearing the enable bit before the first phase has ended stops the timer: no interrupt and no reset follow.
- R8: Once the first phase has ended, a control write with bit 31 clear leaves the enable bit at 1 and the reset still arrives at its scheduled cycle.
- R9: Writing 1 to bit 31 or bit 30 of the status word at offset 0x4 clears that bit, and writing 0 leaves it set. The interrupt output follows status bit 31.
- R10: The control word at offset 0x8 reads back every written field at its position: bit 31, bits 30:29, bits 26:22, bits 19:15 and bits 1:0. All other bits read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous system reset |
| bus_wr_i | input | 1 | Register write strobe, one write per cycle |
| bus_addr_i | input | ADDR_W | Byte offset: 0x0 kick, 0x4 status, 0x8 control |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i, combinational |
| irq_pre_o | output | 1 | Pre-timeout interrupt, level of status bit 31 |
| rst_soc_o | output | 1 | One-cycle full-chip reset request |
| rst_cpu_o | output | 1 | One-cycle CPU reset request |
| rst_sw_o | output | 1 | One-cycle software reset request |

## Verification
The bound checker checks these rules on every cycle:
- The reset outputs stay one-hot-or-idle and each pulse lasts a single cycle.
- A reset pulse always comes with status bit 30 set and with the enable bit dropped.
- A disabled timer never produces a reset.
- The enable bit holds while the lock is set.
- The pre-timeout flag stays set until a write of 1 clears it.

Cycle-exact tick and phase lengths under different scale and limit values depend on the time since a specific write, so only the directed scenarios can show them. The same applies to a kick restarting the count, a zero-valued kick being ignored, and which output each mode selects.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

   // Control word layout (software decodes these positions)
   localparam int CTL_EN_BIT   = 31;
   localparam int CTL_SEL_LSB  = 29;
   localparam int CTL_L1_LSB   = 22;
   localparam int CTL_L2_LSB   = 15;
   localparam int CTL_MODE_LSB = 0;

   // Status word bits
   localparam int STS_PRE_BIT  = 31;
   localparam int STS_RST_BIT  = 30;

   // Kick bit in the kick word
   localparam int KICK_BIT     = 31;

   // Field widths
   localparam int SEL_W  = 2;
   localparam int LIM_W  = 5;
   localparam int MODE_W = 2;

   // Byte offsets of the three words
   localparam logic [3:0] OFF_KICK = 4'h0;
   localparam logic [3:0] OFF_STS  = 4'h4;
   localparam logic [3:0] OFF_CTL  = 4'h8;

   // Mode value loaded at reset
   localparam logic [MODE_W-1:0] MODE_DEFAULT = 2'd1;

   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ONE  = 2'd1,
      PH_TWO  = 2'd2
   } phase_e;

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
   parameter int BASE_LOG2 = 25,
   parameter int SEL_W     = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic [SEL_W-1:0] sel_i,
   output logic             tick_o
);
   localparam int MAX_SEL = (1 << SEL_W) - 1;
   localparam int CNT_W   = BASE_LOG2 + MAX_SEL;

   logic [CNT_W-1:0] presc_q;
   logic [CNT_W-1:0] mask;

   // Low BASE_LOG2+sel bits all ones marks the last cycle of a tick
   always_comb begin
      mask = {CNT_W{1'b1}} >> (MAX_SEL - int'(sel_i));
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i || restart_i) begin
         presc_q <= '0;
      end else begin
         presc_q <= presc_q + 1'b1;
      end
   end

   assign tick_o = run_i && ((presc_q & mask) == mask);

endmodule

// File: rtl/wdt_phase_seq.sv
module wdt_phase_seq
   import wdt_pkg::*;
#(
   parameter int LIM_W = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             run_i,
   input  logic             restart_i,
   input  logic             tick_i,
   input  logic [LIM_W-1:0] lim1_i,
   input  logic [LIM_W-1:0] lim2_i,
   output logic             p1_done_o,
   output logic             p2_done_o
);
   phase_e           phase_q;
   logic [LIM_W-1:0] cnt_q;
   logic             step;

   assign step      = run_i && !restart_i && tick_i;
   assign p1_done_o = step && (phase_q == PH_ONE) && (cnt_q == lim1_i);
   assign p2_done_o = step && (phase_q == PH_TWO) && (cnt_q == lim2_i);

   always_ff @(posedge clk_i) begin
      if (!rst_ni || !run_i) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (restart_i || phase_q == PH_IDLE) begin
         phase_q <= PH_ONE;
         cnt_q   <= '0;
      end else if (p1_done_o) begin
         phase_q <= PH_TWO;
         cnt_q   <= '0;
      end else if (p2_done_o) begin
         phase_q <= PH_IDLE;
         cnt_q   <= '0;
      end else if (step) begin
         cnt_q   <= cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/wdt_reset_drive.sv
module wdt_reset_drive #(
   parameter int N_OUT  = 3,
   parameter int MODE_W = 2
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              fire_i,
   input  logic [MODE_W-1:0] mode_i,
   output logic [N_OUT-1:0]  pulse_o
);
   logic [N_OUT-1:0] hit;

   // Output 0 also takes every mode value with no output of its own
   for (genvar i = 0; i < N_OUT; i++) begin : g_out
      if (i == 0) begin : g_default
         assign hit[i] = (int'(mode_i) == 0) || (int'(mode_i) >= N_OUT);
      end else begin : g_plain
         assign hit[i] = (int'(mode_i) == i);
      end

      always_ff @(posedge clk_i) begin
         if (!rst_ni) begin
            pulse_o[i] <= 1'b0;
         end else begin
            pulse_o[i] <= fire_i && hit[i];
         end
      end
   end

endmodule

// File: rtl/wdt_two_phase.sv
module wdt_two_phase
   import wdt_pkg::*;
#(
   parameter int BASE_LOG2 = 25,
   parameter int ADDR_W    = 4
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [31:0]       bus_wdata_i,
   output logic [31:0]       bus_rdata_o,
   output logic              irq_pre_o,
   output logic              rst_soc_o,
   output logic              rst_cpu_o,
   output logic              rst_sw_o
);
   localparam int N_RST = 3;

   if (BASE_LOG2 < 1 || BASE_LOG2 > 40) begin : g_chk_base
      $error("BASE_LOG2 out of range");
   end
   if (ADDR_W < 4) begin : g_chk_addr
      $error("ADDR_W must hold offset 0x8");
   end

   // Register state
   logic              ctrl_en;
   logic [SEL_W-1:0]  ctl_sel_q;
   logic [LIM_W-1:0]  ctl_l1_q;
   logic [LIM_W-1:0]  ctl_l2_q;
   logic [MODE_W-1:0] ctl_mode_q;
   logic              lock_q;
   logic              st_pre_q;
   logic              st_rst_q;

   logic              wr_kick, wr_sts, wr_ctl;
   logic              kick;
   logic              tick, p1_done, p2_done;
   logic [N_RST-1:0]  rst_pulse;

   assign wr_kick = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_KICK));
   assign wr_sts  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_STS));
   assign wr_ctl  = bus_wr_i && (bus_addr_i == ADDR_W'(OFF_CTL));
   assign kick    = wr_kick && bus_wdata_i[KICK_BIT];

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         ctrl_en    <= 1'b0;
         ctl_sel_q  <= '0;
         ctl_l1_q   <= '0;
         ctl_l2_q   <= '0;
         ctl_mode_q <= MODE_DEFAULT;
         lock_q     <= 1'b0;
      end else begin
         if (wr_ctl) begin
            ctl_sel_q  <= bus_wdata_i[CTL_SEL_LSB  +: SEL_W];
            ctl_l1_q   <= bus_wdata_i[CTL_L1_LSB   +: LIM_W];
            ctl_l2_q   <= bus_wdata_i[CTL_L2_LSB   +: LIM_W];
            ctl_mode_q <= bus_wdata_i[CTL_MODE_LSB +: MODE_W];
         end
         if (p2_done) begin
            ctrl_en <= 1'b0;
            lock_q  <= 1'b0;
         end else begin
            if (wr_ctl) begin
               ctrl_en <= bus_wdata_i[CTL_EN_BIT] || lock_q || p1_done;
            end
            if (p1_done) begin
               lock_q <= 1'b1;
            end
         end
      end
   end

   // Sticky flags: a new event wins over a clear in the same cycle
   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_pre_q <= 1'b0;
         st_rst_q <= 1'b0;
      end else begin
         if (p1_done) begin
            st_pre_q <= 1'b1;
         end else if (wr_sts && bus_wdata_i[STS_PRE_BIT]) begin
            st_pre_q <= 1'b0;
         end
         if (p2_done) begin
            st_rst_q <= 1'b1;
         end else if (wr_sts && bus_wdata_i[STS_RST_BIT]) begin
            st_rst_q <= 1'b0;
         end
      end
   end

   wdt_tick_gen #(
      .BASE_LOG2 (BASE_LOG2),
      .SEL_W     (SEL_W)
   ) u_tick (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (ctrl_en),
      .restart_i (kick),
      .sel_i     (ctl_sel_q),
      .tick_o    (tick)
   );

   wdt_phase_seq #(
      .LIM_W (LIM_W)
   ) u_seq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .run_i     (ctrl_en),
      .restart_i (kick),
      .tick_i    (tick),
      .lim1_i    (ctl_l1_q),
      .lim2_i    (ctl_l2_q),
      .p1_done_o (p1_done),
      .p2_done_o (p2_done)
   );

   wdt_reset_drive #(
      .N_OUT  (N_RST),
      .MODE_W (MODE_W)
   ) u_rst (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .fire_i  (p2_done),
      .mode_i  (ctl_mode_q),
      .pulse_o (rst_pulse)
   );

   assign rst_soc_o = rst_pulse[0];
   assign rst_cpu_o = rst_pulse[1];
   assign rst_sw_o  = rst_pulse[2];
   assign irq_pre_o = st_pre_q;

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(OFF_STS)) begin
         bus_rdata_o[STS_PRE_BIT] = st_pre_q;
         bus_rdata_o[STS_RST_BIT] = st_rst_q;
      end else if (bus_addr_i == ADDR_W'(OFF_CTL)) begin
         bus_rdata_o[CTL_EN_BIT]               = ctrl_en;
         bus_rdata_o[CTL_SEL_LSB  +: SEL_W]    = ctl_sel_q;
         bus_rdata_o[CTL_L1_LSB   +: LIM_W]    = ctl_l1_q;
         bus_rdata_o[CTL_L2_LSB   +: LIM_W]    = ctl_l2_q;
         bus_rdata_o[CTL_MODE_LSB +: MODE_W]   = ctl_mode_q;
      end
   end

endmodule

// File: rtl/wdt_two_phase_chk.sv
module wdt_two_phase_chk #(
   parameter int ADDR_W = 4
) (
   input logic              clk_i,
   input logic              rst_ni,
   input logic              bus_wr_i,
   input logic [ADDR_W-1:0] bus_addr_i,
   input logic [31:0]       bus_wdata_i,
   input logic              irq_pre_o,
   input logic              rst_soc_o,
   input logic              rst_cpu_o,
   input logic              rst_sw_o,
   input logic              ctrl_en,
   input logic              lock_q,
   input logic              st_pre_q,
   input logic              st_rst_q
);
   logic any_rst;
   logic clr_pre;

   assign any_rst = rst_soc_o || rst_cpu_o || rst_sw_o;
   assign clr_pre = bus_wr_i && (bus_addr_i == ADDR_W'(4'h4)) && bus_wdata_i[31];

   a_r5_reset_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0({rst_soc_o, rst_cpu_o, rst_sw_o}));

   a_r4_pulse_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_rst |=> !any_rst);

   a_r4_status_with_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_rst |-> st_rst_q);

   a_r4_enable_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
      any_rst |-> !ctrl_en);

   a_r7_idle_no_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ctrl_en |=> !any_rst);

   a_r8_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lock_q |=> (ctrl_en || any_rst));

   a_r9_pre_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_pre_q && !clr_pre) |=> st_pre_q);

   a_r3_irq_needs_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(irq_pre_o) |-> $past(ctrl_en));

endmodule

bind wdt_two_phase wdt_two_phase_chk #(.ADDR_W(ADDR_W)) u_chk (
   .clk_i       (clk_i),
   .rst_ni      (rst_ni),
   .bus_wr_i    (bus_wr_i),
   .bus_addr_i  (bus_addr_i),
   .bus_wdata_i (bus_wdata_i),
   .irq_pre_o   (irq_pre_o),
   .rst_soc_o   (rst_soc_o),
   .rst_cpu_o   (rst_cpu_o),
   .rst_sw_o    (rst_sw_o),
   .ctrl_en     (ctrl_en),
   .lock_q      (lock_q),
   .st_pre_q    (st_pre_q),
   .st_rst_q    (st_rst_q)
);

// File: tb/tb_wdt_two_phase.sv
module tb_wdt_two_phase;
   localparam int BASE_LOG2 = 4;
   localparam int P0        = 1 << BASE_LOG2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr = 1'b0;
   logic [3:0]  addr = 4'h0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq, r_soc, r_cpu, r_sw;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   int n_soc = 0, n_cpu = 0, n_sw = 0;
   bit done = 0;

   always #10 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (r_soc) n_soc++;
      if (r_cpu) n_cpu++;
      if (r_sw)  n_sw++;
   end

   wdt_two_phase #(.BASE_LOG2(BASE_LOG2), .ADDR_W(4)) dut (
      .clk_i(clk), .rst_ni(rst_n), .bus_wr_i(wr), .bus_addr_i(addr),
      .bus_wdata_i(wdata), .bus_rdata_o(rdata), .irq_pre_o(irq),
      .rst_soc_o(r_soc), .rst_cpu_o(r_cpu), .rst_sw_o(r_sw)
   );

   function automatic logic [31:0] mk(bit en, int sel, int l1, int l2, int mode);
      logic [31:0] v = '0;
      v[31]    = en;
      v[30:29] = 2'(sel);
      v[26:22] = 5'(l1);
      v[19:15] = 5'(l2);
      v[1:0]   = 2'(mode);
      return v;
   endfunction

   task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
      end
   endtask

   task automatic apply_reset();
      rst_n = 1'b0;
      wr = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      n_soc = 0; n_cpu = 0; n_sw = 0;
   endtask

   // Called at a negedge; the write lands on the next posedge
   task automatic bus_write(logic [3:0] a, logic [31:0] d);
      addr = a; wdata = d; wr = 1'b1;
      @(negedge clk);
      wr = 1'b0;
   endtask

   task automatic bus_read(logic [3:0] a, output logic [31:0] d);
      addr = a;
      #1;
      d = rdata;
   endtask

   task automatic wait_to(int t);
      while (cyc < t) @(negedge clk);
   endtask

   task automatic t_reset_state();
      logic [31:0] d;
      apply_reset();
      bus_read(4'h8, d);
      check(d == 32'h1, "R1 ctrl default", d, 32'h1);
      bus_read(4'h4, d);
      check(d == 32'h0, "R1 status default", d, 32'h0);
      check({irq, r_soc, r_cpu, r_sw} == 4'b0, "R1 outputs low",
            {28'b0, irq, r_soc, r_cpu, r_sw}, 32'h0);
   endtask

   task automatic t_layout();
      logic [31:0] d;
      logic [31:0] v;
      apply_reset();
      v = mk(0, 2, 5, 9, 2);
      bus_write(4'h8, v | 32'h1860_7FFC);
      bus_read(4'h8, d);
      check(d == v, "R10 ctrl readback", d, v);
   endtask

   task automatic t_shortest();
      logic [31:0] d;
      int e;
      apply_reset();
      bus_write(4'h8, mk(1, 0, 0, 0, 0));
      e = cyc;
      wait_to(e + P0 - 1);
      check(irq == 1'b0, "R2 no irq before first tick", irq, 0);
      wait_to(e + P0);
      check(irq == 1'b1, "R3 irq after one tick", irq, 1);
      bus_read(4'h4, d);
      check(d == 32'h8000_0000, "R3 status bit31", d, 32'h8000_0000);
      wait_to(e + 2*P0 - 1);
      check(r_soc == 1'b0, "R4 no reset early", r_soc, 0);
      wait_to(e + 2*P0);
      check(r_soc == 1'b1, "R4 soc pulse mode0", r_soc, 1);
      wait_to(e + 2*P0 + 1);
      check(r_soc == 1'b0, "R4 pulse one cycle", r_soc, 0);
      check(n_soc == 1 && n_cpu == 0 && n_sw == 0, "R5 only soc output",
            32'(n_soc*100 + n_cpu*10 + n_sw), 32'd100);
      bus_read(4'h8, d);
      check(d == 32'h0, "R4 enable cleared", d, 32'h0);
      bus_read(4'h4, d);
      check(d == 32'hC000_0000, "R4 status bit30", d, 32'hC000_0000);
      // R9 write-one-to-clear
      bus_write(4'h4, 32'h0);
      bus_read(4'h4, d);
      check(d == 32'hC000_0000, "R9 zero write keeps", d, 32'hC000_0000);
      bus_write(4'h4, 32'h8000_0000);
      bus_read(4'h4, d);
      check(d == 32'h4000_0000, "R9 clear bit31", d, 32'h4000_0000);
      check(irq == 1'b0, "R9 irq follows bit31", irq, 0);
      bus_write(4'h4, 32'h4000_0000);
      bus_read(4'h4, d);
      check(d == 32'h0, "R9 clear bit30", d, 32'h0);
   endtask

   task automatic t_scaled();
      int e, p;
      apply_reset();
      p = P0 * 2;
      bus_write(4'h8, mk(1, 1, 2, 1, 1));
      e = cyc;
      wait_to(e + 3*p - 1);
      check(irq == 1'b0, "R2 scaled irq not early", irq, 0);
      wait_to(e + 3*p);
      check(irq == 1'b1, "R3 scaled irq on time", irq, 1);
      wait_to(e + 5*p - 1);
      check(r_cpu == 1'b0, "R4 scaled no early reset", r_cpu, 0);
      wait_to(e + 5*p);
      check(r_cpu == 1'b1, "R5 cpu pulse mode1", r_cpu, 1);
      wait_to(e + 5*p + 2);
      check(n_cpu == 1 && n_soc == 0 && n_sw == 0, "R5 only cpu output",
            32'(n_soc*100 + n_cpu*10 + n_sw), 32'd10);
   endtask

   task automatic t_mode(int mode, int exp_code);
      int e;
      apply_reset();
      bus_write(4'h8, mk(1, 0, 0, 0, mode));
      e = cyc;
      wait_to(e + 2*P0 + 2);
      check(n_soc*100 + n_cpu*10 + n_sw == exp_code, "R5 mode output select",
            32'(n_soc*100 + n_cpu*10 + n_sw), 32'(exp_code));
   endtask

   task automatic t_disable();
      int e;
      apply_reset();
      bus_write(4'h8, mk(1, 0, 3, 0, 0));
      e = cyc;
      wait_to(e + 30);
      bus_write(4'h8, mk(0, 0, 3, 0, 0));
      wait_to(e + 200);
      check(irq == 1'b0, "R7 no irq after disable", irq, 0);
      check(n_soc + n_cpu + n_sw == 0, "R7 no reset after disable",
            32'(n_soc + n_cpu + n_sw), 0);
   endtask

   task automatic t_lock();
      logic [31:0] d;
      int e;
      apply_reset();
      bus_write(4'h8, mk(1, 0, 0, 3, 1));
      e = cyc;
      wait_to(e + P0);
      check(irq == 1'b1, "R3 irq before lock test", irq, 1);
      bus_write(4'h8, mk(0, 0, 0, 3, 1));
      bus_read(4'h8, d);
      check(d[31] == 1'b1, "R8 enable stays set", d, mk(1, 0, 0, 3, 1));
      wait_to(e + 5*P0 - 1);
      check(r_cpu == 1'b0, "R8 reset not early", r_cpu, 0);
      wait_to(e + 5*P0);
      check(r_cpu == 1'b1, "R8 reset still arrives", r_cpu, 1);
   endtask

   task automatic t_kick();
      int e, k;
      apply_reset();
      bus_write(4'h8, mk(1, 0, 1, 0, 1));
      e = cyc;
      wait_to(e + 10);
      bus_write(4'h0, 32'h7FFF_FFFF);   // bit31 clear: ignored
      wait_to(e + 2*P0 - 1);
      check(irq == 1'b0, "R6 zero kick irq not early", irq, 0);
      wait_to(e + 2*P0);
      check(irq == 1'b1, "R6 zero kick has no effect", irq, 1);
      apply_reset();
      bus_write(4'h8, mk(1, 0, 1, 0, 1));
      e = cyc;
      wait_to(e + 20);
      bus_write(4'h0, 32'h8000_0000);
      k = cyc;
      wait_to(e + 2*P0);
      check(irq == 1'b0, "R6 kick delays irq", irq, 0);
      wait_to(k + 2*P0 - 1);
      check(irq == 1'b0, "R6 irq not early after kick", irq, 0);
      wait_to(k + 2*P0);
      check(irq == 1'b1, "R6 irq two ticks after kick", irq, 1);
   endtask

   initial begin
      t_reset_state();
      t_layout();
      t_shortest();
      t_scaled();
      t_mode(2, 1);     // software reset
      t_mode(3, 100);   // mode 3 behaves as full-chip
      t_mode(0, 100);
      t_disable();
      t_lock();
      t_kick();
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=0x%08h expected=0x%08h", 32'(cyc), 0);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule